// File: doc/BRIEF.md
# Pin change interrupt controller

This block watches two groups of general-purpose input pins, group A with eight pins and group B with five, and raises one interrupt flag per group whenever any enabled pin in that group changes level, in either direction. Each pin passes through a two-flop synchroniser. A change is found by comparing the synchronised value with its value one cycle earlier. A per-pin mask chooses which pins take part.

Software reaches the block through a small register port with a same-cycle read path: one mask register per group, a group-enable register and a flag register cleared by writing one. A global interrupt enable input and per-group enable bits gate the flags onto two registered interrupt request lines. The interrupt sequencer also clears a group's flag when it takes that group's vector, by pulsing the group's acknowledge input for one cycle.

Top module: `pin_change_irq`

## Requirements
- R1: Register address 0 holds the 8-bit group A mask. Address 1 holds the 5-bit group B mask in bits 4:0. Bits 7:5 of address 1 read as zero, and writes to them are ignored.
- R2: A rising or a falling change on a group's pin whose mask bit is one sets that group's flag. The flag reads as one from the third rising clock edge after the pin change onward. Flags are at address 3: bit 0 is group A and bit 1 is group B.
- R3: A change on a pin whose mask bit is zero never sets its group's flag.
- R4: `irq[g]` is registered. It is one on the cycle after the cycle in which flag g, enable bit g and `gie` are all one, and it is zero otherwise.
- R5: A one-cycle pulse on `ack[g]` clears flag g and leaves the other group's flag unchanged.
- R6: Writing a one to a bit of address 3 clears that flag. Writing a zero leaves the flag unchanged.
- R7: After reset, the masks, group enables, flags and `irq` are all zero. A pin level that is held steady through reset does not set a flag after reset is released.
- R8: If a qualifying change reaches a group in the same cycle as a write-one clear or an acknowledge for that group, the flag stays one.
- R9: Address 2 holds the group enable bits: bit 0 is group A and bit 1 is group B. A read returns the current register value in the same cycle and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_a | input | 8 | Group A pin inputs, asynchronous |
| pins_b | input | 5 | Group B pin inputs, asynchronous |
| gie | input | 1 | Global interrupt enable |
| ack | input | 2 | Per-group vector-taken pulse from the sequencer |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data, same cycle |
| irq | output | 2 | Per-group interrupt request |

## Verification
The flag properties assume that `ack` is a single-cycle pulse and that a pin is not toggled again before its previous change has reached the flag. They also assume that the pins settle through reset long enough for the synchroniser to fill. The bench holds reset for several cycles with the pins steady, and it changes pins only on falling clock edges. It waits at least three edges between changes and drives acknowledges and writes for one cycle at a time. The same-cycle set-against-clear cases are placed deliberately on the edge where the detected change meets the clear.

// File: rtl/pcirq_pkg.sv
package pcirq_pkg;
  localparam int GRP_A_W = 8;
  localparam int GRP_B_W = 5;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 2;
  localparam int NGRP    = 2;

  localparam logic [ADDR_W-1:0] ADR_MASK_A = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_MASK_B = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_GEN    = 2'd2;
  localparam logic [ADDR_W-1:0] ADR_FLAG   = 2'd3;
endpackage

// File: rtl/pcirq_sync.sv
module pcirq_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] chg_o
);
  logic [W-1:0] s1_q, s2_q, prev_q;

  // synchroniser keeps sampling through reset so it is full on release
  always_ff @(posedge clk) begin
    s1_q <= pin_i;
    s2_q <= s1_q;
  end

  // during reset, track the value s2 will take so no change is seen on release
  always_ff @(posedge clk) begin
    if (rst) prev_q <= s1_q;
    else     prev_q <= s2_q;
  end

  assign chg_o = s2_q ^ prev_q;
endmodule

// File: rtl/pcirq_group.sv
module pcirq_group #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin_i,
  input  logic         mask_we,
  input  logic [W-1:0] mask_wd,
  output logic [W-1:0] mask_o,
  input  logic         clr_i,
  input  logic         ack_i,
  input  logic         en_i,
  input  logic         gie_i,
  output logic         flag_o,
  output logic         irq_o
);
  logic [W-1:0] chg;
  logic [W-1:0] mask_q;
  logic         flag_q, irq_q;
  logic         hit;

  pcirq_sync #(.W(W)) sync_i (
    .clk   (clk),
    .rst   (rst),
    .pin_i (pin_i),
    .chg_o (chg)
  );

  assign hit = |(chg & mask_q);

  always_ff @(posedge clk) begin
    if (rst)          mask_q <= '0;
    else if (mask_we) mask_q <= mask_wd;
  end

  // a fresh change takes priority over either clear source
  always_ff @(posedge clk) begin
    if (rst)                  flag_q <= 1'b0;
    else if (hit)             flag_q <= 1'b1;
    else if (clr_i || ack_i)  flag_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= flag_q & en_i & gie_i;
  end

  assign mask_o = mask_q;
  assign flag_o = flag_q;
  assign irq_o  = irq_q;

  AST_SET_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> $past(hit)); // R3
  AST_CHANGE_SETS: assert property (@(posedge clk) disable iff (rst)
    hit |=> flag_q); // R2
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (hit && (clr_i || ack_i)) |=> flag_q); // R8
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (ack_i && !hit) |=> !flag_q); // R5
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !hit) |=> !flag_q); // R6
  AST_FALL_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $fell(flag_q) |-> $past(clr_i || ack_i)); // R6
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> $past(flag_q && en_i && gie_i)); // R4
  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (flag_q && en_i && gie_i) |=> irq_q); // R4
endmodule

// File: rtl/pin_change_irq.sv
module pin_change_irq
  import pcirq_pkg::*;
#(
  parameter int A_W = GRP_A_W,
  parameter int B_W = GRP_B_W,
  parameter int D_W = DATA_W,
  parameter int AW  = ADDR_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [A_W-1:0] pins_a,
  input  logic [B_W-1:0] pins_b,
  input  logic           gie,
  input  logic [1:0]     ack,
  input  logic           bus_we,
  input  logic [AW-1:0]  bus_addr,
  input  logic [D_W-1:0] bus_wdata,
  output logic [D_W-1:0] bus_rdata,
  output logic [1:0]     irq
);
  localparam int PAD_B = D_W - B_W;
  localparam int PAD_G = D_W - NGRP;

  logic [A_W-1:0]  mask_a;
  logic [B_W-1:0]  mask_b;
  logic [NGRP-1:0] gen_q, flags, clr;
  logic            we_ma, we_mb, we_gen, we_flag;

  assign we_ma   = bus_we && (bus_addr == ADR_MASK_A);
  assign we_mb   = bus_we && (bus_addr == ADR_MASK_B);
  assign we_gen  = bus_we && (bus_addr == ADR_GEN);
  assign we_flag = bus_we && (bus_addr == ADR_FLAG);
  assign clr     = we_flag ? bus_wdata[NGRP-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst)         gen_q <= '0;
    else if (we_gen) gen_q <= bus_wdata[NGRP-1:0];
  end

  pcirq_group #(.W(A_W)) grp_a_i (
    .clk (clk), .rst (rst), .pin_i (pins_a),
    .mask_we (we_ma), .mask_wd (bus_wdata[A_W-1:0]), .mask_o (mask_a),
    .clr_i (clr[0]), .ack_i (ack[0]), .en_i (gen_q[0]), .gie_i (gie),
    .flag_o (flags[0]), .irq_o (irq[0])
  );

  pcirq_group #(.W(B_W)) grp_b_i (
    .clk (clk), .rst (rst), .pin_i (pins_b),
    .mask_we (we_mb), .mask_wd (bus_wdata[B_W-1:0]), .mask_o (mask_b),
    .clr_i (clr[1]), .ack_i (ack[1]), .en_i (gen_q[1]), .gie_i (gie),
    .flag_o (flags[1]), .irq_o (irq[1])
  );

  always_comb begin
    case (bus_addr)
      ADR_MASK_A: bus_rdata = mask_a;
      ADR_MASK_B: bus_rdata = {{PAD_B{1'b0}}, mask_b};
      ADR_GEN:    bus_rdata = {{PAD_G{1'b0}}, gen_q};
      default:    bus_rdata = {{PAD_G{1'b0}}, flags};
    endcase
  end

  AST_GEN_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !we_gen |=> $stable(gen_q)); // R9
endmodule

// File: tb/pin_change_irq_tb.sv
`timescale 1ns/1ps
module pin_change_irq_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] pa = 8'hA5;
  logic [4:0] pb = 5'h0A;
  logic       gie = 1'b0;
  logic [1:0] ack = 2'b00;
  logic       we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wd = 8'h00;
  logic [7:0] rd;
  logic [1:0] irq;
  int n_run = 0;
  int n_fail = 0;
  logic [7:0] v;

  always #2.5 clk = ~clk;

  pin_change_irq dut_i (
    .clk (clk), .rst (rst), .pins_a (pa), .pins_b (pb), .gie (gie),
    .ack (ack), .bus_we (we), .bus_addr (addr), .bus_wdata (wd),
    .bus_rdata (rd), .irq (irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rdreg(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    #0.5;
    d = rd;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wd = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  // flips one pin, returns at the falling edge after the flag edge
  task automatic toggle(input int g, input int i);
    @(negedge clk);
    if (g == 0) pa[i] = ~pa[i]; else pb[i] = ~pb[i];
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 8'h0, 8'h1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (6) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    for (int a = 0; a < 4; a++) begin
      rdreg(a[1:0], v);
      chk("R7 reset register", v, 8'h00);
    end
    chk("R7 reset irq", {6'b0, irq}, 8'h00);

    // held pin levels must not flag after release
    wr(2'd0, 8'hFF); wr(2'd1, 8'hFF);
    repeat (5) @(negedge clk);
    rdreg(2'd3, v);
    chk("R7 no spurious flag", v, 8'h00);

    // R1 mask widths
    rdreg(2'd0, v); chk("R1 mask A", v, 8'hFF);
    rdreg(2'd1, v); chk("R1 mask B upper zero", v, 8'h1F);
    wr(2'd1, 8'hE4);
    rdreg(2'd1, v); chk("R1 mask B write", v, 8'h04);

    // sweep every pin of both groups
    for (int g = 0; g < 2; g++) begin
      for (int i = 0; i < (g == 0 ? 8 : 5); i++) begin
        logic [7:0] m;
        logic [7:0] fexp;
        m = 8'h01 << i;
        fexp = (g == 0) ? 8'h01 : 8'h02;
        wr(2'd0, 8'h00); wr(2'd1, 8'h00);
        wr(g[1:0], m);
        wr(2'd3, 8'h03);
        toggle(g, i);
        rdreg(2'd3, v); chk("R2 first change", v, fexp);
        wr(2'd3, 8'h03);
        toggle(g, i);
        rdreg(2'd3, v); chk("R2 opposite change", v, fexp);
        wr(2'd3, 8'h03);
        wr(g[1:0], ~m);
        toggle(g, i);
        rdreg(2'd3, v); chk("R3 masked pin", v, 8'h00);
      end
    end

    // both flags set, then gating of irq
    wr(2'd0, 8'hFF); wr(2'd1, 8'h1F);
    toggle(0, 3);
    toggle(1, 2);
    rdreg(2'd3, v); chk("R2 both flags", v, 8'h03);
    for (int gi = 0; gi < 2; gi++) begin
      for (int e = 0; e < 4; e++) begin
        @(negedge clk);
        gie = gi[0];
        wr(2'd2, e[7:0]);
        rdreg(2'd2, v); chk("R9 enable readback", v, e[7:0]);
        @(negedge clk);
        chk("R4 irq gating", {6'b0, irq}, gi[0] ? e[7:0] : 8'h00);
      end
    end
    rdreg(2'd3, v); chk("R9 read no side effect", v, 8'h03);

    // write zero keeps flags
    wr(2'd3, 8'h00);
    rdreg(2'd3, v); chk("R6 write zero", v, 8'h03);
    wr(2'd3, 8'h02);
    rdreg(2'd3, v); chk("R6 write one B", v, 8'h01);

    // acknowledge clears only its own group
    toggle(1, 0);
    @(negedge clk); ack = 2'b01;
    @(negedge clk); ack = 2'b00;
    rdreg(2'd3, v); chk("R5 ack A", v, 8'h02);
    @(negedge clk); chk("R5 irq after ack", {6'b0, irq}, 8'h02);

    // change meets acknowledge on the same edge
    @(negedge clk); pb[4] = ~pb[4];
    repeat (2) @(posedge clk);
    @(negedge clk); ack = 2'b10;
    @(negedge clk); ack = 2'b00;
    rdreg(2'd3, v); chk("R8 set beats ack", v, 8'h02);

    // change meets write-one clear on the same edge
    @(negedge clk); pa[6] = ~pa[6];
    repeat (2) @(posedge clk);
    @(negedge clk); we = 1'b1; addr = 2'd3; wd = 8'h03;
    @(negedge clk); we = 1'b0;
    rdreg(2'd3, v); chk("R8 set beats write clear", v, 8'h01);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule